// File: doc/BRIEF.md
# Masked Multi-Lane Data Comparator

This block checks a stream of received 32-bit words against the words the receiver expected to see. Each word is spread across a compare structure that was laid out for four lanes of 20 bits. The low 20 bits of the word fill the first lane. The upper 12 bits fill the bottom of the second lane. The top of the second lane and all of the third and fourth lanes carry no data. A programmable mask per lane switches comparison off bit by bit. This lets the narrow stream run in the wide structure with the empty bit positions masked off.

For every word presented with the valid strobe, the block raises one registered flag per lane that holds an unmasked difference. An error tracker records the result. It is a small state machine with three states:
- `ST_CLEAN`: no mismatch seen since reset or since the last clear.
- `ST_FAULT`: at least one mismatch has been counted.
- `ST_PINNED`: the error counter has reached its maximum and holds there.

The tracker moves between its states on these transitions:
- CLEAN→FAULT on the first mismatching word.
- FAULT→PINNED when the counter reaches full scale.
- Any state→CLEAN on a software clear.

All the per-lane masks, the lane flags, the sticky flag and the counter can be reached through a simple word-wide register port. Writes to this port are synchronous and reads are combinational.

Top module: `lane_cmp_top`

## Requirements
- R1: After reset the lane flags, sticky flag and error count are 0. The masks read back as lane 0 = 0x00000, lane 1 = 0xFF000, and lanes 2 and 3 = 0xFFFFF. A mask bit is set exactly where the lane bit lies beyond the 32 data bits.
- R2: Received and expected bit i (0..19) feed lane 0 bit i. Bits 20..31 feed lane 1 bits 0..11. The remaining lane bits are zero on both sides.
- R3: A mask bit of 1 disables comparison of its lane bit. A mask bit of 0 enables it.
- R4: Lane flag n (port bit n) is the OR over lane n of (received XOR expected) AND NOT mask. It appears on the clock edge that samples valid. After an edge with valid low, all lane flags are 0.
- R5: The sticky flag sets on the first valid word with any lane mismatch. It stays set until a clear.
- R6: The error count rises by exactly one for each valid word with at least one lane mismatch, however many lanes differ. A valid word with no mismatch leaves the count unchanged.
- R7: The count saturates at 65535. Further mismatching words leave it at 65535.
- R8: Writing a word with bit 0 = 1 to address 5 zeroes the sticky flag and the count on that edge. A mismatch on the same edge is not counted. Writing bit 0 = 0 to address 5 has no effect.
- R9: Addresses 0..3 read and write the lane 0..3 masks in bits 19:0. Address 4 reads status: bit 0 = sticky, bits 7:4 = lane flags, bits 31:16 = count. Writes to address 4 are ignored. Addresses 6 and 7 read 0.
- R10: The tracker uses the states and transitions named above. The sticky flag is set exactly when the state is not `ST_CLEAN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Received/expected pair is present |
| rx_word | input | 32 | Received data word |
| exp_word | input | 32 | Expected data word |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| lane_miss | output | 4 | Registered per-lane mismatch flags |
| err_sticky | output | 1 | Sticky error flag |
| err_count | output | 16 | Saturating mismatch-word counter |

## Verification
The assertions assume that `cmp_valid`, the data words and the write controls are never unknown once reset has been released. They also assume that a clear write and a mismatching word may arrive on the same edge, and that the clear then wins. The bench changes every input half a cycle away from the sampling edge and keeps all of them driven to known values from time zero. It places the one deliberate clear-plus-mismatch collision on a single edge and checks the outcome at the ports.

// File: rtl/lcmp_pkg.sv
package lcmp_pkg;
    localparam int LANE_W   = 20;
    localparam int N_LANES  = 4;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 16;
    localparam int ADDR_W   = 3;
    localparam int REG_W    = 32;
    localparam int STAT_ADR = 4;
    localparam int CLR_ADR  = 5;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_FAULT  = 2'd1,
        ST_PINNED = 2'd2
    } trk_state_e;
endpackage

// File: rtl/lane_slice.sv
module lane_slice #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid,
    input  logic [W-1:0] rx,
    input  logic [W-1:0] ex,
    input  logic [W-1:0] mask,
    output logic         diff_c,
    output logic         miss_q
);
    always_comb begin
        diff_c = |((rx ^ ex) & ~mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) miss_q <= 1'b0;
        else        miss_q <= valid & diff_c;
    end

    // R4: an edge without valid leaves the flag clear
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> !miss_q);
    // R3: equal or fully masked input never flags
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ((rx ^ ex) & ~mask) == '0) |=> !miss_q);
endmodule

// File: rtl/mask_regs.sv
module mask_regs #(
    parameter int W      = 20,
    parameter int N      = 4,
    parameter int DATA_W = 32,
    parameter int AW     = 3,
    parameter int RW     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [RW-1:0]       wr_data,
    output logic [N-1:0][W-1:0] masks
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    function automatic logic [W-1:0] rst_mask(input int lane);
        logic [W-1:0] m;
        for (int b = 0; b < W; b++) m[b] = ((lane * W + b) >= DATA_W);
        return m;
    endfunction

    for (genvar l = 0; l < N; l++) begin : g_mask
        localparam logic [W-1:0] RST_V = rst_mask(l);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                masks[l] <= RST_V;
            end else if (wr_en && wr_addr == AW'(l)) begin
                masks[l] <= wr_data[W-1:0];
            end
        end
    end

    // R9: a mask changes only through a write to its address
    p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_addr >= AW'(N)) |=> $stable(masks));

    logic [IDX_W-1:0] unused_idx;
    assign unused_idx = '0;
endmodule

// File: rtl/err_fsm.sv
module err_fsm
    import lcmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          clr,
    output logic          sticky,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CMAX  = '1;
    localparam logic [CW-1:0] CNEAR = CMAX - 1'b1;

    trk_state_e state, nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CLEAN;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (clr) begin
            nxt = ST_CLEAN;
        end else begin
            unique case (state)
                ST_CLEAN:  if (hit) nxt = (CMAX == 1) ? ST_PINNED : ST_FAULT;
                ST_FAULT:  if (hit && count == CNEAR) nxt = ST_PINNED;
                ST_PINNED: nxt = ST_PINNED;
                default:   nxt = ST_CLEAN;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (hit && state != ST_PINNED) begin
            count <= count + 1'b1;
        end
    end

    assign sticky = (state != ST_CLEAN);

    // R5: sticky holds until a clear
    p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && !clr) |=> sticky);
    // R6: count never falls without a clear and rises by at most one
    p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) || count == $past(count) + 1'b1));
    // R7: saturated count stays put
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CMAX && !clr) |=> count == CMAX);
    // R8: clear empties the tracker
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !sticky));
    // R10: pinned state only with full count
    p_pinned_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PINNED) |-> count == CMAX);
endmodule

// File: rtl/lane_cmp_top.sv
module lane_cmp_top
    import lcmp_pkg::*;
#(
    parameter int LW  = LANE_W,
    parameter int NL  = N_LANES,
    parameter int DW  = DATA_W,
    parameter int CW  = CNT_W,
    parameter int AW  = ADDR_W,
    parameter int RW  = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_valid,
    input  logic [DW-1:0] rx_word,
    input  logic [DW-1:0] exp_word,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [RW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [RW-1:0] rd_data,
    output logic [NL-1:0] lane_miss,
    output logic          err_sticky,
    output logic [CW-1:0] err_count
);
    localparam int PAD_W = NL * LW;
    localparam int IDX_W = (NL > 1) ? $clog2(NL) : 1;

    logic [PAD_W-1:0]       rx_pad, ex_pad;
    logic [NL-1:0][LW-1:0]  masks;
    logic [NL-1:0]          diff_c;
    logic                   hit, clr;

    assign rx_pad = {{(PAD_W - DW){1'b0}}, rx_word};
    assign ex_pad = {{(PAD_W - DW){1'b0}}, exp_word};

    mask_regs #(.W(LW), .N(NL), .DATA_W(DW), .AW(AW), .RW(RW)) u_masks (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .masks(masks)
    );

    for (genvar l = 0; l < NL; l++) begin : g_lane
        lane_slice #(.W(LW)) u_slice (
            .clk(clk), .rst_n(rst_n), .valid(cmp_valid),
            .rx(rx_pad[l*LW +: LW]), .ex(ex_pad[l*LW +: LW]),
            .mask(masks[l]), .diff_c(diff_c[l]), .miss_q(lane_miss[l])
        );
    end

    assign hit = cmp_valid && (|diff_c);
    assign clr = wr_en && (wr_addr == AW'(CLR_ADR)) && wr_data[0];

    err_fsm #(.CW(CW)) u_trk (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr),
        .sticky(err_sticky), .count(err_count)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr < AW'(NL)) begin
            rd_data[LW-1:0] = masks[rd_addr[IDX_W-1:0]];
        end else if (rd_addr == AW'(STAT_ADR)) begin
            rd_data[0]             = err_sticky;
            rd_data[4 +: NL]       = lane_miss;
            rd_data[RW-1 -: CW]    = err_count;
        end
    end

    // R5: any lane flag implies sticky, unless cleared on that edge
    p_flag_sets_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr) |=> err_sticky);
    // R10: sticky exactly when count nonzero
    p_sticky_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky == (err_count != '0));
endmodule

// File: tb/sim_lane_cmp_top.sv
module sim_lane_cmp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [31:0] rx_word = '0, exp_word = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  lane_miss;
    logic        err_sticky;
    logic [15:0] err_count;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lane_cmp_top u0 (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .rx_word(rx_word),
        .exp_word(exp_word), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .lane_miss(lane_miss),
        .err_sticky(err_sticky), .err_count(err_count)
    );

    typedef struct packed {
        logic [31:0] rx;
        logic [31:0] ex;
        logic [3:0]  fl;
    } vec_t;

    // default masks: lane0 none, lane1 upper 8, lanes 2/3 all (R2, R4)
    localparam vec_t VECS [8] = '{
        '{32'h0000_0000, 32'h0000_0000, 4'b0000},
        '{32'h0000_0001, 32'h0000_0000, 4'b0001},
        '{32'h0010_0000, 32'h0000_0000, 4'b0010},
        '{32'h8000_0000, 32'h0000_0000, 4'b0010},
        '{32'h8008_0000, 32'h0000_0000, 4'b0011},
        '{32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0000},
        '{32'hFFFF_FFFF, 32'h0000_0000, 4'b0011},
        '{32'h000F_FFFF, 32'h000F_FFFE, 4'b0001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] rx, input logic [31:0] ex);
        cmp_valid = v; rx_word = rx; exp_word = ex;
        @(posedge clk); @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rreg(input string req, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a; #0.5;
        chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 flags", {28'd0, lane_miss}, 32'd0);
        chk("R1 sticky", {31'd0, err_sticky}, 32'd0);
        chk("R1 count", {16'd0, err_count}, 32'd0);
        rreg("R1 mask0", 3'd0, 32'h0000_0000);
        rreg("R1 mask1", 3'd1, 32'h000F_F000);
        rreg("R1 mask2", 3'd2, 32'h000F_FFFF);
        rreg("R1 mask3", 3'd3, 32'h000F_FFFF);

        // R2/R4 table walk
        for (int i = 0; i < 8; i++) begin
            step(1'b1, VECS[i].rx, VECS[i].ex);
            chk($sformatf("R2 R4 vec%0d", i), {28'd0, lane_miss}, {28'd0, VECS[i].fl});
        end
        chk("R6 count after table", {16'd0, err_count}, 32'd6);
        chk("R5 sticky after table", {31'd0, err_sticky}, 32'd1);
        rreg("R9 status", 3'd4, {16'd6, 8'd0, 4'b0001, 3'd0, 1'b1});

        // R4 valid low ignores differences
        step(1'b0, 32'hFFFF_FFFF, 32'h0);
        chk("R4 idle flags", {28'd0, lane_miss}, 32'd0);
        chk("R4 idle count", {16'd0, err_count}, 32'd6);

        // R3 masking
        wreg(3'd0, 32'h0000_0001);
        step(1'b1, 32'h1, 32'h0);
        chk("R3 masked bit", {28'd0, lane_miss}, 32'd0);
        step(1'b1, 32'h2, 32'h0);
        chk("R3 open bit", {28'd0, lane_miss}, 32'd1);
        wreg(3'd1, 32'hFFFF_FFFF);
        rreg("R9 mask1 rw", 3'd1, 32'h000F_FFFF);
        step(1'b1, 32'hFFF0_0000, 32'h0);
        chk("R3 lane1 masked", {28'd0, lane_miss}, 32'd0);
        chk("R6 count masked", {16'd0, err_count}, 32'd7);

        // R9 unused address and status write
        rreg("R9 addr6", 3'd6, 32'd0);
        wreg(3'd4, 32'hFFFF_FFFF);
        chk("R9 status write ignored", {16'd0, err_count}, 32'd7);

        // R8 clear
        wreg(3'd5, 32'h0000_0000);
        chk("R8 clear bit0=0", {16'd0, err_count}, 32'd7);
        wreg(3'd5, 32'h0000_0001);
        chk("R8 clear count", {16'd0, err_count}, 32'd0);
        chk("R8 clear sticky", {31'd0, err_sticky}, 32'd0);
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'h1;
        step(1'b1, 32'h2, 32'h0);
        wr_en = 1'b0;
        chk("R8 collide count", {16'd0, err_count}, 32'd0);
        chk("R8 collide flag", {28'd0, lane_miss}, 32'd1);

        // R7 saturation
        wreg(3'd0, 32'h0);
        cmp_valid = 1'b1; rx_word = 32'h1; exp_word = 32'h0;
        repeat (65540) @(posedge clk);
        @(negedge clk);
        cmp_valid = 1'b0;
        chk("R7 saturated", {16'd0, err_count}, 32'd65535);
        chk("R10 sticky pinned", {31'd0, err_sticky}, 32'd1);
        wreg(3'd5, 32'h1);
        chk("R10 back clean", {31'd0, err_sticky}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule